// File: doc/BRIEF.md
# Storage Fault Entry Unit

This unit performs the one-cycle architectural update that happens when a storage fault interrupt is taken. An instruction-side fetch fault or a data-side access fault arrives as a single-cycle request pulse, together with its cause flags. The unit also receives the address of the faulting instruction, the live machine state word, the failing data address, the upper half of the vector prefix and the current machine-check syndrome bit.

When it accepts a fault, the unit registers a new set of values in the next cycle:
- the two save registers;
- the data fault address (data faults only);
- a rewritten syndrome word;
- a machine state word with the interrupt-disabling bits cleared;
- the redirected program counter.

It also raises a one-cycle entry pulse that tells the pipeline to load these values.

A program fault that coincides with a data fault wins. In that case this unit leaves all of its state unchanged so that the program-fault logic can act. Bit numbers below use big-endian order: bit 0 is the most significant bit of a 32-bit word, so big-endian bit n is vector index 31-n.

Top module: `stor_fault_entry`

## Requirements
- R1: After reset, every output is zero, including the entry pulse and the kind flag.
- R2: A lone data fault request produces, one cycle later, the following: the entry pulse is high, the kind flag is low, save register 0 equals the faulting instruction address, save register 1 equals the machine state word from before entry, and the fault address register equals the failing data address.
- R3: The new PC is the 16-bit prefix followed by 0x0300 for a data fault, and the prefix followed by 0x0400 for an instruction fault.
- R4: The new machine state word equals the old one with bits 6, 12, 13, 16, 17, 18, 20, 21, 23, 26 and 27 cleared (mask 0x020CED30). All other bits keep their value, including 14, 19 and 22.
- R5: On a data fault, the syndrome sets its store flag at bit 8 from the store cause, its zone flag at bit 9 from the zone cause and its attribute flag at bit 15 from the attribute cause.
- R6: The syndrome's machine-check bit 0 takes the current machine-check input, and every syndrome bit not named in R5 or R7 is zero after entry.
- R7: On an instruction fault, the kind flag is high, save register 0 equals the fetch address, the zone flag at bit 9 follows the instruction zone cause, and bits 8 and 15 are zero.
- R8: An instruction fault leaves the fault address register unchanged.
- R9: When a program fault and a data fault are requested in the same cycle, no storage entry is taken and all registered outputs keep their values.
- R10: An instruction fault request is taken ahead of any simultaneous program or data fault request.
- R11: Requests that arrive in the cycle when the entry pulse is high are ignored.
- R12: The entry pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifault_req_i | input | 1 | Instruction fetch fault request pulse |
| ifault_zone_i | input | 1 | Fetch fault came from a user-mode zone-00 access |
| dfault_req_i | input | 1 | Data access fault request pulse |
| dfault_store_i | input | 1 | Faulting access was a store |
| dfault_zone_i | input | 1 | Data fault came from a user-mode zone-00 access |
| dfault_attr_i | input | 1 | Enabled user-attribute fault hit |
| pfault_req_i | input | 1 | Program fault request for the same instruction |
| pc_i | input | 32 | Address of the faulting instruction |
| msr_i | input | 32 | Current machine state word |
| daddr_i | input | 32 | Failing data address |
| vpfx_i | input | 16 | Upper half of the vector prefix |
| mchk_i | input | 1 | Current machine-check syndrome bit |
| enter_o | output | 1 | One-cycle entry pulse |
| ifault_o | output | 1 | Kind of the last entry: 1 for instruction, 0 for data |
| save0_o | output | 32 | Return address save register |
| save1_o | output | 32 | Saved machine state |
| daddr_o | output | 32 | Captured fault address |
| synd_o | output | 32 | Rewritten syndrome word |
| msr_o | output | 32 | New machine state word |
| pc_o | output | 32 | Redirected program counter |

## Verification
The two cases that are hardest to reach from the ports are a request dropped because it lands in the busy cycle, and a request suppressed by a coinciding program fault. Neither case produces any output activity. The bench first loads every output with distinctive values from an earlier entry. It then raises the competing or late request with different operand values and confirms that none of those values appear. Instruction-fault entries likewise follow a data entry, so that a retained fault address can be told apart from a rewritten one.

// File: rtl/stor_fault_entry.sv
module stor_fault_entry #(
  parameter int W  = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ifault_req_i,
  input  logic          ifault_zone_i,
  input  logic          dfault_req_i,
  input  logic          dfault_store_i,
  input  logic          dfault_zone_i,
  input  logic          dfault_attr_i,
  input  logic          pfault_req_i,
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  msr_i,
  input  logic [W-1:0]  daddr_i,
  input  logic [PW-1:0] vpfx_i,
  input  logic          mchk_i,
  output logic          enter_o,
  output logic          ifault_o,
  output logic [W-1:0]  save0_o,
  output logic [W-1:0]  save1_o,
  output logic [W-1:0]  daddr_o,
  output logic [W-1:0]  synd_o,
  output logic [W-1:0]  msr_o,
  output logic [W-1:0]  pc_o
);

  localparam int OW = W - PW;

  function automatic logic [W-1:0] be_bit(input int n);
    logic [W-1:0] v;
    v = '0;
    v[W-1-n] = 1'b1;
    return v;
  endfunction

  localparam logic [W-1:0] MSR_CLR =
      be_bit(6)  | be_bit(12) | be_bit(13) | be_bit(16) | be_bit(17) | be_bit(18) |
      be_bit(20) | be_bit(21) | be_bit(23) | be_bit(26) | be_bit(27);

  localparam int S_MCHK = W - 1 - 0;
  localparam int S_STOR = W - 1 - 8;
  localparam int S_ZONE = W - 1 - 9;
  localparam int S_ATTR = W - 1 - 15;

  localparam logic [OW-1:0] OFS_DATA  = OW'(16'h0300);
  localparam logic [OW-1:0] OFS_INSTR = OW'(16'h0400);

  logic take_i, take_d, go;
  logic [W-1:0] synd_n;

  assign take_i = ~enter_o & ifault_req_i;
  assign take_d = ~enter_o & dfault_req_i & ~pfault_req_i & ~ifault_req_i;
  assign go     = take_i | take_d;

  always_comb begin
    synd_n = '0;
    synd_n[S_MCHK] = mchk_i;
    if (take_i) begin
      synd_n[S_ZONE] = ifault_zone_i;
    end else begin
      synd_n[S_STOR] = dfault_store_i;
      synd_n[S_ZONE] = dfault_zone_i;
      synd_n[S_ATTR] = dfault_attr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enter_o  <= 1'b0;
      ifault_o <= 1'b0;
      save0_o  <= '0;
      save1_o  <= '0;
      daddr_o  <= '0;
      synd_o   <= '0;
      msr_o    <= '0;
      pc_o     <= '0;
    end else begin
      enter_o <= go;
      if (go) begin
        ifault_o <= take_i;
        save0_o  <= pc_i;
        save1_o  <= msr_i;
        synd_o   <= synd_n;
        msr_o    <= msr_i & ~MSR_CLR;
        pc_o     <= {vpfx_i, take_i ? OFS_INSTR : OFS_DATA};
        if (take_d) daddr_o <= daddr_i;
      end
    end
  end

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |=> !enter_o);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |=> $stable(save0_o) && $stable(pc_o));

  p_prog_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dfault_req_i && pfault_req_i && !ifault_req_i) |=> !enter_o && $stable(save0_o));

  p_dtake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dfault_req_i && !pfault_req_i && !ifault_req_i && !enter_o) |=>
      enter_o && !ifault_o && save1_o == $past(msr_i) && daddr_o == $past(daddr_i));

  p_iprio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ifault_req_i && !enter_o) |=> enter_o && ifault_o);

  p_keep_daddr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && ifault_o) |-> $stable(daddr_o));

  p_msr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> ((msr_o & MSR_CLR) == '0) && ((msr_o | MSR_CLR) == (save1_o | MSR_CLR)));

  p_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> pc_o[W-1:OW] == $past(vpfx_i));

endmodule

// File: tb/stor_fault_entry_bench.sv
module stor_fault_entry_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ireq = 0, izone = 0, dreq = 0, dstore = 0, dzone = 0, dattr = 0, preq = 0, mchk = 0;
  logic [31:0] pc = 0, msr = 0, daddr = 0;
  logic [15:0] vpfx = 0;
  logic enter, ikind;
  logic [31:0] save0, save1, daddr_q, synd, msr_q, pc_q;
  int checks = 0, errors = 0;

  localparam logic [31:0] CLR = 32'h020C_ED30;

  always #4 clk = ~clk;

  stor_fault_entry u_stor_fault_entry (
    .clk(clk), .rst_n(rst_n),
    .ifault_req_i(ireq), .ifault_zone_i(izone),
    .dfault_req_i(dreq), .dfault_store_i(dstore), .dfault_zone_i(dzone), .dfault_attr_i(dattr),
    .pfault_req_i(preq), .pc_i(pc), .msr_i(msr), .daddr_i(daddr), .vpfx_i(vpfx), .mchk_i(mchk),
    .enter_o(enter), .ifault_o(ikind), .save0_o(save0), .save1_o(save1),
    .daddr_o(daddr_q), .synd_o(synd), .msr_o(msr_q), .pc_o(pc_q));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic i, input logic d, input logic p, input logic [31:0] a_pc,
                       input logic [31:0] a_msr, input logic [31:0] a_ea, input logic [15:0] a_pfx);
    ireq = i; dreq = d; preq = p; pc = a_pc; msr = a_msr; daddr = a_ea; vpfx = a_pfx;
  endtask

  task automatic step;
    @(negedge clk);
    ireq = 0; dreq = 0; preq = 0;
  endtask

  task automatic t_reset;
    chk("R1", "enter", {31'b0, enter}, 0);
    chk("R1", "kind", {31'b0, ikind}, 0);
    chk("R1", "save0", save0, 0);
    chk("R1", "save1", save1, 0);
    chk("R1", "daddr", daddr_q, 0);
    chk("R1", "synd", synd, 0);
    chk("R1", "msr", msr_q, 0);
    chk("R1", "pc", pc_q, 0);
  endtask

  task automatic t_data_store;
    dstore = 1; dzone = 0; dattr = 1; mchk = 1;
    drive(0, 1, 0, 32'h1000_0040, 32'hFFFF_FFFF, 32'hDEAD_BEEC, 16'hABCD);
    step;
    chk("R2", "enter", {31'b0, enter}, 1);
    chk("R2", "kind", {31'b0, ikind}, 0);
    chk("R2", "save0", save0, 32'h1000_0040);
    chk("R2", "save1", save1, 32'hFFFF_FFFF);
    chk("R2", "daddr", daddr_q, 32'hDEAD_BEEC);
    chk("R3", "pc", pc_q, 32'hABCD_0300);
    chk("R4", "msr", msr_q, 32'hFFFF_FFFF & ~CLR);
    chk("R5", "synd", synd, 32'h8081_0000);
    step;
    chk("R12", "enter drop", {31'b0, enter}, 0);
  endtask

  task automatic t_data_zone;
    dstore = 0; dzone = 1; dattr = 0; mchk = 0;
    drive(0, 1, 0, 32'h3000_0008, 32'h0002_1200, 32'h1234_5678, 16'h0F0F);
    step;
    chk("R4", "msr keep", msr_q, 32'h0002_1200);
    chk("R5", "synd zone", synd, 32'h0040_0000);
    chk("R6", "mchk clear", {31'b0, synd[31]}, 0);
    chk("R2", "daddr", daddr_q, 32'h1234_5678);
    step;
  endtask

  task automatic t_instr;
    izone = 1; mchk = 1; dstore = 1; dattr = 1;
    drive(1, 0, 0, 32'h2000_0100, 32'h0000_C000, 32'hAAAA_0000, 16'h5555);
    step;
    chk("R7", "kind", {31'b0, ikind}, 1);
    chk("R7", "save0", save0, 32'h2000_0100);
    chk("R7", "synd", synd, 32'h8040_0000);
    chk("R6", "synd mchk", {31'b0, synd[31]}, 1);
    chk("R8", "daddr kept", daddr_q, 32'h1234_5678);
    chk("R3", "pc", pc_q, 32'h5555_0400);
    chk("R4", "msr", msr_q, 32'h0000_0000);
    step;
  endtask

  task automatic t_prog_wins;
    drive(0, 1, 1, 32'h7777_0000, 32'h1111_1111, 32'h9999_9999, 16'h2222);
    step;
    chk("R9", "enter", {31'b0, enter}, 0);
    chk("R9", "save0", save0, 32'h2000_0100);
    chk("R9", "daddr", daddr_q, 32'h1234_5678);
    chk("R9", "pc", pc_q, 32'h5555_0400);
  endtask

  task automatic t_instr_prio;
    izone = 0; mchk = 0;
    drive(1, 1, 1, 32'h4444_0004, 32'h0, 32'hBBBB_BBBB, 16'h1234);
    step;
    chk("R10", "enter", {31'b0, enter}, 1);
    chk("R10", "kind", {31'b0, ikind}, 1);
    chk("R10", "save0", save0, 32'h4444_0004);
    chk("R10", "daddr", daddr_q, 32'h1234_5678);
    step;
  endtask

  task automatic t_busy;
    dstore = 0; dzone = 0; dattr = 0;
    drive(0, 1, 0, 32'h6000_0000, 32'h0, 32'hCCCC_0000, 16'h6666);
    @(negedge clk);
    chk("R11", "first enter", {31'b0, enter}, 1);
    drive(1, 1, 0, 32'h6000_0100, 32'hFFFF_FFFF, 32'hCCCC_0100, 16'h7777);
    step;
    chk("R11", "enter", {31'b0, enter}, 0);
    chk("R11", "save0", save0, 32'h6000_0000);
    chk("R11", "daddr", daddr_q, 32'hCCCC_0000);
    chk("R11", "pc", pc_q, 32'h6666_0300);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_data_store;
        t_data_zone;
        t_instr;
        t_prog_wins;
        t_instr_prio;
        t_busy;
      end
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule